// File: doc/BRIEF.md
# Block Group Access History Table

This block sits next to a memory controller and remembers which blocks of each aligned group of eight consecutive 64-byte blocks were recently filled into the last-level cache. For each of those blocks it also remembers the cache way the fill used. Every last-level cache miss writes one record: the block address and the way the cache chose for it. When a sharer vector later misses in the on-chip directory buffer, the controller queries the table with the missing block's address. The table then lists the later blocks of that group that it saw filled, together with their ways, so that their vectors can be fetched ahead of demand by cache line number.

The table is direct-mapped. The group number (address bits above the group offset) is split into an index, taken from its low bits, and a stored tag. A record whose tag differs from the resident one evicts that entry and starts a fresh history. Answers to a query leave the block one per cycle in ascending block order over a valid/ready handshake. The list is taken as a snapshot in the cycle the query is accepted.

Top module: `grp_hist_table`

## Requirements
- R1: The address ports carry physical address bits 47 down to 6. Bits 8:6 select the block within its group. The group number is bits 47:9; its low log2(ENTRIES) bits index the table and the rest form the tag.
- R2: A record whose tag matches the resident entry sets that block's presence bit and stores its way. The other blocks of the group keep their bits and ways.
- R3: A record whose tag differs from the resident entry, or that hits an empty entry, replaces the entry. Afterwards only the recorded block is present, and a query with the old tag finds nothing.
- R4: Recording a block that is already present overwrites its stored way with the new one.
- R5: A query that hits emits one candidate per present block with a larger block index than the queried one, in ascending block order. Each candidate gives its block index on cand_blk and its stored way on cand_way.
- R6: A query that misses in the table emits no candidate. The queried block and lower blocks are never emitted.
- R7: While cand_valid is high and cand_ready is low, cand_valid, cand_blk and cand_way hold their values.
- R8: When a record and a query arrive in the same cycle, the query sees the table with the record already applied.
- R9: qry_ready is high exactly when no candidate is pending. The first candidate of an accepted query is presented in the cycle after acceptance.
- R10: After reset the table is empty, cand_valid is low and qry_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record strobe, one per cache fill |
| rec_addr | input | 42 | Physical address bits 47:6 of the filled block |
| rec_way | input | 4 | Cache way the block was placed in |
| qry_valid | input | 1 | Query request on a vector miss |
| qry_addr | input | 42 | Physical address bits 47:6 of the missing block |
| qry_ready | output | 1 | Query accepted this cycle when high |
| cand_valid | output | 1 | A prefetch candidate is presented |
| cand_ready | input | 1 | Consumer takes the candidate |
| cand_blk | output | 3 | Block index within the group |
| cand_way | output | 4 | Stored cache way of that block |

## Verification
The bench builds the table with only four entries and keeps the 48-bit address and 16 ways. With so few entries, index aliasing and entry replacement happen on almost every new group. The bench sweeps all 256 presence patterns of a group and queries every block position for each pattern, which covers every combination of present blocks and query position. Back-to-back replacement, way overwrite, same-cycle record and query, and a stalled consumer are each driven on their own.

// File: rtl/ght_pkg.sv
package ght_pkg;
  localparam int unsigned SCAN_W = 32;

  // Bits strictly above position pos, limited to the low n bits.
  function automatic logic [SCAN_W-1:0] above_mask(int unsigned pos, int unsigned n);
    logic [SCAN_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < SCAN_W; i++)
      if (i > pos && i < n) m[i] = 1'b1;
    return m;
  endfunction

  // Position of the least significant set bit (0 when none).
  function automatic int unsigned lowest_one(logic [SCAN_W-1:0] v);
    int unsigned r;
    r = 0;
    for (int i = SCAN_W - 1; i >= 0; i--)
      if (v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/ght_split.sv
module ght_split #(
  parameter int unsigned ADDR_W   = 48,
  parameter int unsigned BLK_LOG2 = 6,
  parameter int unsigned GRP_LOG2 = 3,
  parameter int unsigned IDX_W    = 7,
  localparam int unsigned KEY_W   = ADDR_W - BLK_LOG2 - GRP_LOG2,
  localparam int unsigned TAG_W   = KEY_W - IDX_W
) (
  input  logic [ADDR_W-1:BLK_LOG2] addr,
  output logic [GRP_LOG2-1:0]      blk,
  output logic [IDX_W-1:0]         idx,
  output logic [TAG_W-1:0]         tag
);
  // R1: block within group, then index, then tag
  localparam int unsigned GRP_LSB = BLK_LOG2 + GRP_LOG2;
  assign blk = addr[GRP_LSB-1:BLK_LOG2];
  assign idx = addr[GRP_LSB+IDX_W-1:GRP_LSB];
  assign tag = addr[ADDR_W-1:GRP_LSB+IDX_W];
endmodule

// File: rtl/ght_store.sv
module ght_store #(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned TAG_W   = 32,
  parameter int unsigned BLK_W   = 3,
  parameter int unsigned WAY_W   = 4,
  localparam int unsigned GRP_N  = 1 << BLK_W,
  localparam int unsigned WV_W   = GRP_N * WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [GRP_N-1:0] rd_pres,
  output logic [WV_W-1:0]  rd_ways
);
  logic             vld_q  [ENTRIES];
  logic [TAG_W-1:0] tag_q  [ENTRIES];
  logic [GRP_N-1:0] pres_q [ENTRIES];
  logic [WV_W-1:0]  way_q  [ENTRIES];

  logic             wr_hit;
  logic [GRP_N-1:0] wr_pres_new;
  logic [WV_W-1:0]  wr_ways_new;

  assign wr_hit = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);

  always_comb begin
    wr_pres_new = wr_hit ? pres_q[wr_idx] : '0;
    wr_pres_new[wr_blk] = 1'b1;
    wr_ways_new = way_q[wr_idx];
    for (int b = 0; b < GRP_N; b++)
      if (wr_blk == BLK_W'(b)) wr_ways_new[b*WAY_W +: WAY_W] = wr_way;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e]  <= 1'b0;
        tag_q[e]  <= '0;
        pres_q[e] <= '0;
        way_q[e]  <= '0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        vld_q[e]  <= 1'b1;
        tag_q[e]  <= wr_tag;
        pres_q[e] <= wr_pres_new;
        way_q[e]  <= wr_ways_new;
      end
    end
  end

  // Read view with a same-cycle record already folded in (R8)
  logic             fwd;
  logic             rd_vld;
  logic [TAG_W-1:0] rd_tag_s;
  logic [GRP_N-1:0] rd_pres_s;
  logic [WV_W-1:0]  rd_ways_s;
  logic             rd_hit;

  assign fwd       = wr_en && (wr_idx == rd_idx);
  assign rd_vld    = fwd ? 1'b1        : vld_q[rd_idx];
  assign rd_tag_s  = fwd ? wr_tag      : tag_q[rd_idx];
  assign rd_pres_s = fwd ? wr_pres_new : pres_q[rd_idx];
  assign rd_ways_s = fwd ? wr_ways_new : way_q[rd_idx];
  assign rd_hit    = rd_vld && (rd_tag_s == rd_tag);
  assign rd_pres   = rd_hit ? rd_pres_s : '0;
  assign rd_ways   = rd_ways_s;

  // R2
  rec_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pres_q[$past(wr_idx)][$past(wr_blk)] &&
              (way_q[$past(wr_idx)][$past(wr_blk)*WAY_W +: WAY_W] == $past(wr_way)) &&
              (tag_q[$past(wr_idx)] == $past(wr_tag)));

  // R3
  replace_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_hit |=> $countones(pres_q[$past(wr_idx)]) == 1);
endmodule

// File: rtl/ght_emit.sv
module ght_emit #(
  parameter int unsigned BLK_W = 3,
  parameter int unsigned WAY_W = 4,
  localparam int unsigned GRP_N = 1 << BLK_W,
  localparam int unsigned WV_W  = GRP_N * WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GRP_N-1:0] load_mask,
  input  logic [WV_W-1:0]  load_ways,
  input  logic             cand_ready,
  output logic             cand_valid,
  output logic [BLK_W-1:0] cand_blk,
  output logic [WAY_W-1:0] cand_way,
  output logic             idle
);
  import ght_pkg::*;

  logic [GRP_N-1:0] mask_q;
  logic [WV_W-1:0]  ways_q;
  logic [BLK_W-1:0] pick;
  logic             take;

  assign pick       = BLK_W'(lowest_one(SCAN_W'(mask_q)));
  assign cand_valid = |mask_q;
  assign idle       = ~cand_valid;
  assign cand_blk   = pick;
  assign cand_way   = ways_q[pick*WAY_W +: WAY_W];
  assign take       = cand_valid && cand_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      ways_q <= '0;
    end else if (load) begin
      mask_q <= load_mask;
      ways_q <= load_ways;
    end else if (take) begin
      mask_q[pick] <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_blk) && $stable(cand_way));

  // R5
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !cand_valid || (cand_blk > $past(cand_blk)));
endmodule

// File: rtl/grp_hist_table.sv
module grp_hist_table #(
  parameter int unsigned ADDR_W   = 48,
  parameter int unsigned BLK_LOG2 = 6,
  parameter int unsigned GRP_LOG2 = 3,
  parameter int unsigned ENTRIES  = 128,
  parameter int unsigned LLC_WAYS = 16,
  localparam int unsigned GRP_N   = 1 << GRP_LOG2,
  localparam int unsigned IDX_W   = $clog2(ENTRIES),
  localparam int unsigned WAY_W   = $clog2(LLC_WAYS),
  localparam int unsigned KEY_W   = ADDR_W - BLK_LOG2 - GRP_LOG2,
  localparam int unsigned TAG_W   = KEY_W - IDX_W,
  localparam int unsigned WV_W    = GRP_N * WAY_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rec_valid,
  input  logic [ADDR_W-1:BLK_LOG2] rec_addr,
  input  logic [WAY_W-1:0]         rec_way,
  input  logic                     qry_valid,
  input  logic [ADDR_W-1:BLK_LOG2] qry_addr,
  output logic                     qry_ready,
  output logic                     cand_valid,
  input  logic                     cand_ready,
  output logic [GRP_LOG2-1:0]      cand_blk,
  output logic [WAY_W-1:0]         cand_way
);
  import ght_pkg::*;

  logic [GRP_LOG2-1:0] r_blk, q_blk;
  logic [IDX_W-1:0]    r_idx, q_idx;
  logic [TAG_W-1:0]    r_tag, q_tag;
  logic [GRP_N-1:0]    q_pres, q_mask;
  logic [WV_W-1:0]     q_ways;
  logic                q_fire;
  logic                emit_idle;

  ght_split #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .GRP_LOG2(GRP_LOG2), .IDX_W(IDX_W))
    u_rsplit (.addr(rec_addr), .blk(r_blk), .idx(r_idx), .tag(r_tag));

  ght_split #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2), .GRP_LOG2(GRP_LOG2), .IDX_W(IDX_W))
    u_qsplit (.addr(qry_addr), .blk(q_blk), .idx(q_idx), .tag(q_tag));

  ght_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(GRP_LOG2), .WAY_W(WAY_W))
    u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rec_valid), .wr_idx(r_idx), .wr_tag(r_tag), .wr_blk(r_blk), .wr_way(rec_way),
      .rd_idx(q_idx), .rd_tag(q_tag), .rd_pres(q_pres), .rd_ways(q_ways));

  // R5, R6: keep only blocks above the queried one
  assign q_mask    = q_pres & GRP_N'(above_mask(q_blk, GRP_N));
  assign qry_ready = emit_idle;
  assign q_fire    = qry_valid && qry_ready;

  ght_emit #(.BLK_W(GRP_LOG2), .WAY_W(WAY_W))
    u_emit (
      .clk(clk), .rst_n(rst_n),
      .load(q_fire), .load_mask(q_mask), .load_ways(q_ways),
      .cand_ready(cand_ready), .cand_valid(cand_valid),
      .cand_blk(cand_blk), .cand_way(cand_way), .idle(emit_idle));

  // R6
  only_later_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_fire |=> !cand_valid || (cand_blk > $past(q_blk)));

  // R9
  busy_blocks_qry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> !qry_ready);
endmodule

// File: tb/tb_grp_hist_table.sv
module tb_grp_hist_table;
  localparam int ENT = 4;
  localparam int AW  = 48;
  localparam int IW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rec_valid = 1'b0, qry_valid = 1'b0, cand_ready = 1'b1;
  logic [AW-1:6] rec_addr = '0, qry_addr = '0;
  logic [3:0] rec_way = '0;
  logic qry_ready, cand_valid;
  logic [2:0] cand_blk;
  logic [3:0] cand_way;

  always #4 clk = ~clk;

  grp_hist_table #(.ENTRIES(ENT)) dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_way(rec_way),
    .qry_valid(qry_valid), .qry_addr(qry_addr), .qry_ready(qry_ready),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_blk(cand_blk), .cand_way(cand_way));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // Reference model
  bit      m_vld [ENT];
  longint  m_tag [ENT];
  bit [7:0] m_pres [ENT];
  int      m_way [ENT][8];

  int got_n;
  int got_blk [9];
  int got_way [9];

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: address bits 47:6 = {tag, idx, blk}
  function automatic logic [AW-1:6] mk(longint tag, int idx, int blk);
    return (AW-6)'((tag << (IW + 3)) | (longint'(idx) << 3) | longint'(blk));
  endfunction

  function automatic void m_rec(longint tag, int idx, int blk, int way);
    if (!(m_vld[idx] && m_tag[idx] == tag)) begin
      m_vld[idx] = 1; m_tag[idx] = tag; m_pres[idx] = '0;
    end
    m_pres[idx][blk] = 1'b1;
    m_way[idx][blk] = way;
  endfunction

  task automatic do_rec(longint tag, int idx, int blk, int way);
    @(negedge clk);
    rec_valid = 1; rec_addr = mk(tag, idx, blk); rec_way = 4'(way);
    @(negedge clk);
    rec_valid = 0;
    m_rec(tag, idx, blk, way);
  endtask

  task automatic collect();
    got_n = 0;
    while (cand_valid && got_n < 9) begin
      got_blk[got_n] = cand_blk; got_way[got_n] = cand_way; got_n++;
      @(negedge clk);
    end
  endtask

  task automatic do_qry(longint tag, int idx, int blk);
    @(negedge clk);
    qry_valid = 1; qry_addr = mk(tag, idx, blk);
    @(negedge clk);
    qry_valid = 0;
    collect();
  endtask

  task automatic expect_list(longint tag, int idx, int qb, string req);
    int k;
    bit hit;
    hit = m_vld[idx] && m_tag[idx] == tag;
    k = 0;
    for (int b = qb + 1; b < 8; b++) begin
      if (hit && m_pres[idx][b]) begin
        if (k < got_n) begin
          chk(got_blk[k] == b, {req, " blk"}, got_blk[k], b);
          chk(got_way[k] == m_way[idx][b], {req, " way"}, got_way[k], m_way[idx][b]);
        end
        k++;
      end
    end
    chk(got_n == k, {req, " count"}, got_n, k);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_pres[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10
    chk(cand_valid == 0, "R10 cand_valid", cand_valid, 0);
    chk(qry_ready == 1, "R10 qry_ready", qry_ready, 1);
    do_qry(0, 0, 0);
    chk(got_n == 0, "R10 empty table", got_n, 0);

    // R2 R3 R5 R6 R9: all presence patterns at every query position
    for (int p = 0; p < 256; p++) begin
      int idx;
      longint tg;
      idx = p % ENT;
      tg = longint'(p) + 37'h1_0000_0000;
      for (int b = 7; b >= 0; b--)
        if (p[b]) do_rec(tg, idx, b, (b * 5 + p) % 16);
      for (int qb = 0; qb < 8; qb++) begin
        do_qry(tg, idx, qb);
        expect_list(tg, idx, qb, "R5");
        chk(qry_ready == 1, "R9 ready after drain", qry_ready, 1);
      end
      do_qry(tg + 1000, idx, 0);
      chk(got_n == 0, "R6 tag miss", got_n, 0);
      if (p >= ENT && p[ENT-1:0] != 0 && (p & 3) == idx) begin
        do_qry(tg - ENT, idx, 0);
        chk(got_n == 0, "R3 old tag evicted", got_n, 0);
      end
    end

    // R3: replacement leaves only the new block
    do_rec(77, 1, 0, 1); do_rec(77, 1, 4, 2); do_rec(77, 1, 7, 3);
    do_rec(78, 1, 5, 9);
    do_qry(78, 1, 0);
    chk(got_n == 1 && got_blk[0] == 5 && got_way[0] == 9, "R3 single block", got_n, 1);
    do_qry(77, 1, 0);
    chk(got_n == 0, "R3 stale tag", got_n, 0);

    // R4: way overwrite
    do_rec(90, 2, 2, 3); do_rec(90, 2, 6, 4); do_rec(90, 2, 2, 11);
    do_qry(90, 2, 0);
    chk(got_n == 2, "R4 count", got_n, 2);
    chk(got_way[0] == 11, "R4 new way", got_way[0], 11);
    chk(got_way[1] == 4, "R4 other way kept", got_way[1], 4);

    // R8: record and query in the same cycle, fresh tag
    @(negedge clk);
    rec_valid = 1; rec_addr = mk(123, 3, 5); rec_way = 4'd7;
    qry_valid = 1; qry_addr = mk(123, 3, 1);
    @(negedge clk);
    rec_valid = 0; qry_valid = 0;
    m_rec(123, 3, 5, 7);
    collect();
    chk(got_n == 1, "R8 count", got_n, 1);
    chk(got_blk[0] == 5 && got_way[0] == 7, "R8 blk/way", got_blk[0], 5);

    // R7 R9: stalled consumer
    do_rec(123, 3, 6, 12);
    @(negedge clk);
    cand_ready = 0;
    qry_valid = 1; qry_addr = mk(123, 3, 0);
    @(negedge clk);
    qry_valid = 0;
    chk(cand_valid == 1 && cand_blk == 5, "R9 first cand next cycle", cand_blk, 5);
    chk(qry_ready == 0, "R9 busy", qry_ready, 0);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(cand_valid == 1 && cand_blk == 5 && cand_way == 7, "R7 hold", cand_blk, 5);
    end
    cand_ready = 1;
    @(negedge clk);
    chk(cand_valid == 1 && cand_blk == 6 && cand_way == 12, "R7 advance", cand_blk, 6);
    @(negedge clk);
    chk(cand_valid == 0 && qry_ready == 1, "R9 drained", cand_valid, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule